// File: doc/BRIEF.md
# Timed-Unlock Interrupt Vector Selector

This block holds a small control register that decides where the interrupt vector table lives in program memory. The table sits either at word address zero or at the first word of the boot region. The size of the boot region, and so the start of that region, comes from a fuse input. For any interrupt number, the block returns the word address of that interrupt's vector: the table base plus the interrupt number.

The table location cannot change through a single write. Software first arms a change-enable bit. Within the next four cycles it writes the new location, with the enable bit written as zero. Interrupt delivery is held off from the cycle the enable bit becomes set until one cycle after the accepted write. If no write comes, the hold lasts the four window cycles. This hold is a separate output and never changes the core's global interrupt flag.

Two lock inputs also hold off interrupts, according to where the table lives and which region the program counter is executing in.

Top module: `vec_select_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_block` is 0 when both guard inputs are 0, and `vec_addr` equals `int_num`.
- R2: Register layout. Bit 7 and bit 6 are the two external-interrupt enables, written by every write and driven on `ext_int_en[1:0]`. Bit 1 is the vector select. Bit 0 is the change enable. Bits 5..2 always read 0.
- R3: A write with bit 0 = 1 arms the change window. In the next cycle `rd_data[0]` reads 1 and `irq_block` is 1. This write does not load bit 1.
- R4: A write with bit 0 = 0 that arrives 1 to 4 cycles after the arming write loads bit 1 into the vector select and clears the change enable.
- R5: The vector select does not change on a write made 5 or more cycles after arming, or on a write made without arming.
- R6: After an accepted select write, `irq_block` stays 1 for exactly one more cycle and then drops.
- R7: If no select write arrives, the change enable and `irq_block` stay 1 for exactly four cycles and then both return to 0.
- R8: `vec_addr` = base + `int_num`. The base is 0 when the select is 0. When the select is 1, the base is 4096 − (1024 >> `boot_fuse`) with the default widths: fuse 0 gives 0xC00, fuse 1 gives 0xE00, fuse 2 gives 0xF00 and fuse 3 gives 0xF80.
- R9: With the select at 1 and `guard_app_run` = 1, `irq_block` is 1 exactly when `pc` < base. With the select at 0, `guard_app_run` has no effect.
- R10: With the select at 0 and `guard_boot_run` = 1, `irq_block` is 1 exactly when `pc` ≥ base. With the select at 1, `guard_boot_run` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| ext_int_en | output | 2 | External-interrupt enables (bit 1 = register bit 7) |
| pc | input | PC_W (12) | Program counter, word address |
| boot_fuse | input | FUSE_W (2) | Boot-region size selector |
| guard_app_run | input | 1 | Block interrupts in the application region while vectors are in boot |
| guard_boot_run | input | 1 | Block interrupts in the boot region while vectors are in the application region |
| int_num | input | IDX_W (5) | Interrupt number to translate |
| vec_addr | output | PC_W (12) | Vector word address for `int_num` |
| irq_block | output | 1 | Interrupts held off when 1 |

## Verification
A wrong window counter shows up on `rd_data[0]` and `irq_block` in the cycle after the fault. The enable then drops a cycle early or late, and a select write at four or five cycles lands on the wrong side of the window. A corrupt vector-select bit shows up at once on `vec_addr` and in the lock-driven `irq_block` for every program counter near the region boundary. A stuck hold flag shows up as `irq_block` staying high one cycle past an accepted write.

// File: rtl/vs_pkg.sv
package vs_pkg;
    localparam int WIN_CYCLES = 4;
    localparam int CNT_W      = $clog2(WIN_CYCLES);

    localparam int BIT_EN1  = 7;
    localparam int BIT_EN0  = 6;
    localparam int BIT_VSEL = 1;
    localparam int BIT_CE   = 0;

    typedef struct packed {
        logic [1:0]       ext_en;
        logic             vsel;
        logic             ce;
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } ctl_t;
endpackage

// File: rtl/vs_boot_base.sv
module vs_boot_base #(
    parameter int PC_W     = 12,
    parameter int BOOT_MAX = 1024,
    parameter int FUSE_W   = 2
) (
    input  logic [FUSE_W-1:0] boot_fuse,
    output logic [PC_W-1:0]   boot_base
);
    localparam int MEM_WORDS = 1 << PC_W;
    localparam int EXT_W     = PC_W + 1;

    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] diff;

    always_comb begin
        span      = EXT_W'(BOOT_MAX) >> boot_fuse;
        diff      = EXT_W'(MEM_WORDS) - span;
        boot_base = diff[PC_W-1:0];
    end

    initial begin
        if (BOOT_MAX > MEM_WORDS) $error("boot region larger than memory");
    end
endmodule

// File: rtl/vs_unlock.sv
module vs_unlock
    import vs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [1:0] ext_en,
    output logic       vsel,
    output logic       ce,
    output logic       unlock_block
);
    ctl_t s_d, s_q;
    logic arm, take;

    always_comb begin
        arm  = wr_en && wr_data[BIT_CE];
        take = wr_en && s_q.ce && !wr_data[BIT_CE];
        s_d      = s_q;
        s_d.hold = 1'b0;
        if (wr_en) s_d.ext_en = {wr_data[BIT_EN1], wr_data[BIT_EN0]};
        if (arm) begin
            s_d.ce  = 1'b1;
            s_d.cnt = CNT_W'(WIN_CYCLES - 1);
        end else if (take) begin
            s_d.vsel = wr_data[BIT_VSEL];
            s_d.ce   = 1'b0;
            s_d.cnt  = '0;
            s_d.hold = 1'b1;
        end else if (s_q.ce) begin
            if (s_q.cnt == '0) s_d.ce  = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ext_en       = s_q.ext_en;
    assign vsel         = s_q.vsel;
    assign ce           = s_q.ce;
    assign unlock_block = s_q.ce || s_q.hold;

    AST_ARM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[BIT_CE] |=> ce && unlock_block); // R3
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ce && !wr_en && s_q.cnt == '0 |=> !ce); // R7
    AST_SEL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ce && !wr_data[BIT_CE]) |=> $stable(vsel)); // R5
    AST_TAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ce && !wr_data[BIT_CE] |=> unlock_block && !ce); // R6
endmodule

// File: rtl/vs_region_guard.sv
module vs_region_guard #(
    parameter int PC_W  = 12,
    parameter int IDX_W = 5
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  boot_base,
    input  logic             vsel,
    input  logic             guard_app_run,
    input  logic             guard_boot_run,
    input  logic [IDX_W-1:0] int_num,
    output logic             lock_block,
    output logic [PC_W-1:0]  vec_addr
);
    logic in_boot;
    logic [PC_W-1:0] tbl_base;

    always_comb begin
        in_boot    = (pc >= boot_base);
        lock_block = (vsel && guard_app_run && !in_boot) ||
                     (!vsel && guard_boot_run && in_boot);
        tbl_base   = vsel ? boot_base : '0;
        vec_addr   = tbl_base + PC_W'(int_num);
    end
endmodule

// File: rtl/vec_select_ctrl.sv
module vec_select_ctrl #(
    parameter int PC_W     = 12,
    parameter int BOOT_MAX = 1024,
    parameter int FUSE_W   = 2,
    parameter int VEC_CNT  = 19,
    parameter int IDX_W    = $clog2(VEC_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [1:0]        ext_int_en,
    input  logic [PC_W-1:0]   pc,
    input  logic [FUSE_W-1:0] boot_fuse,
    input  logic              guard_app_run,
    input  logic              guard_boot_run,
    input  logic [IDX_W-1:0]  int_num,
    output logic [PC_W-1:0]   vec_addr,
    output logic              irq_block
);
    logic [PC_W-1:0] boot_base;
    logic vsel, ce, unlock_block, lock_block;

    vs_boot_base #(.PC_W(PC_W), .BOOT_MAX(BOOT_MAX), .FUSE_W(FUSE_W)) u_base (
        .boot_fuse (boot_fuse),
        .boot_base (boot_base)
    );

    vs_unlock u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ext_en       (ext_int_en),
        .vsel         (vsel),
        .ce           (ce),
        .unlock_block (unlock_block)
    );

    vs_region_guard #(.PC_W(PC_W), .IDX_W(IDX_W)) u_guard (
        .pc             (pc),
        .boot_base      (boot_base),
        .vsel           (vsel),
        .guard_app_run  (guard_app_run),
        .guard_boot_run (guard_boot_run),
        .int_num        (int_num),
        .lock_block     (lock_block),
        .vec_addr       (vec_addr)
    );

    assign rd_data   = {ext_int_en, 4'b0000, vsel, ce};
    assign irq_block = unlock_block || lock_block;

    AST_APP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        vsel && guard_app_run && (pc < boot_base) |-> irq_block); // R9
    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsel && guard_boot_run && (pc >= boot_base) |-> irq_block); // R10
    AST_VEC_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[1] |-> vec_addr == PC_W'(int_num)); // R8
endmodule

// File: tb/sim_vec_select_ctrl.sv
module sim_vec_select_ctrl;
    logic clk = 1'b0;
    logic rst_n, wr_en, guard_app_run, guard_boot_run, irq_block;
    logic [7:0] wr_data, rd_data;
    logic [1:0] ext_int_en, boot_fuse;
    logic [11:0] pc, vec_addr;
    logic [4:0] int_num;

    int checks = 0;
    int errors = 0;
    bit exp_vsel = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_select_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_int_en(ext_int_en), .pc(pc),
        .boot_fuse(boot_fuse), .guard_app_run(guard_app_run),
        .guard_boot_run(guard_boot_run), .int_num(int_num),
        .vec_addr(vec_addr), .irq_block(irq_block)
    );

    function automatic int ebase(int f);
        return 4096 - (1024 >> f);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic set_sel(bit v);
        wr(8'h01);
        wr({6'b0, v, 1'b0});
        tick();
        exp_vsel = v;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; pc = '0; boot_fuse = '0;
        guard_app_run = 1'b0; guard_boot_run = 1'b0; int_num = 5'd7;
        tick(); tick();
        chk("R1 reg", rd_data, 8'h00);
        chk("R1 block", irq_block, 0);
        chk("R1 vec", vec_addr, 7);
        rst_n = 1'b1;
        tick();

        // R2 and R5: all bits written without arming
        wr(8'hFE);
        chk("R2 read", rd_data, 8'hC0);
        chk("R2 enables", ext_int_en, 2'b11);
        chk("R5 unarmed", rd_data[1], 0);
        chk("R2 block", irq_block, 0);

        // R3 then R7: arm and let the window expire
        wr(8'h41);
        chk("R3 read", rd_data, 8'h41);
        chk("R3 block", irq_block, 1);
        for (int i = 2; i <= 5; i++) begin
            tick();
            chk("R7 ce", rd_data[0], (i <= 4) ? 1 : 0);
            chk("R7 block", irq_block, (i <= 4) ? 1 : 0);
        end

        // R4 R5 R6: select write at 1..5 cycles after arming
        for (int d = 1; d <= 5; d++) begin
            bit tgt;
            tgt = !exp_vsel;
            wr(8'h01);
            chk("R3 arm", rd_data[0], 1);
            chk("R3 arm block", irq_block, 1);
            for (int i = 1; i < d; i++) begin
                tick();
                chk("R7 window", irq_block, (i + 1 <= 4) ? 1 : 0);
            end
            wr({6'b0, tgt, 1'b0});
            if (d <= 4) exp_vsel = tgt;
            chk(d <= 4 ? "R4 sel" : "R5 late", rd_data[1], exp_vsel);
            chk("R4 ce clear", rd_data[0], 0);
            chk("R6 hold", irq_block, (d <= 4) ? 1 : 0);
            tick();
            chk("R6 release", irq_block, 0);
        end

        // R8: vector address sweep
        set_sel(1'b1);
        for (int f = 0; f < 4; f++) begin
            for (int n = 0; n < 19; n++) begin
                boot_fuse = 2'(f); int_num = 5'(n);
                #1;
                chk("R8 boot vec", vec_addr, ebase(f) + n);
            end
        end
        set_sel(1'b0);
        for (int n = 0; n < 19; n++) begin
            int_num = 5'(n);
            #1;
            chk("R8 app vec", vec_addr, n);
        end

        // R9 R10: guards, select at 0
        for (int g = 0; g < 2; g++) begin
            guard_boot_run = (g == 0); guard_app_run = (g == 1);
            for (int f = 0; f < 4; f++) begin
                for (int k = 0; k < 4; k++) begin
                    int p;
                    p = (k == 0) ? 0 : (k == 1) ? ebase(f) - 1 : (k == 2) ? ebase(f) : 4095;
                    boot_fuse = 2'(f); pc = 12'(p);
                    #1;
                    if (g == 0) chk("R10 boot guard", irq_block, (p >= ebase(f)) ? 1 : 0);
                    else        chk("R9 no effect", irq_block, 0);
                end
            end
        end
        guard_app_run = 1'b0; guard_boot_run = 1'b0;
        set_sel(1'b1);
        for (int g = 0; g < 2; g++) begin
            guard_app_run = (g == 0); guard_boot_run = (g == 1);
            for (int f = 0; f < 4; f++) begin
                for (int k = 0; k < 4; k++) begin
                    int p;
                    p = (k == 0) ? 0 : (k == 1) ? ebase(f) - 1 : (k == 2) ? ebase(f) : 4095;
                    boot_fuse = 2'(f); pc = 12'(p);
                    #1;
                    if (g == 0) chk("R9 app guard", irq_block, (p < ebase(f)) ? 1 : 0);
                    else        chk("R10 no effect", irq_block, 0);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule